// File: doc/BRIEF.md
# FIFO Threshold Offset Loader

This block supplies the two distance values that a FIFO's flag logic compares against its fill level: an almost-empty offset, counted from the empty boundary, and an almost-full offset, counted from the full boundary. The FIFO storage and the flag comparators sit elsewhere. This unit only decides which offset values they use and when those values become final.

During master reset the unit samples a 3-bit select input and a parity option. Five select codes give fixed offsets, and the same value is applied to both thresholds. One code enables loading over the port A data bus, where each offset takes one strobed write. Another code enables loading through a one-bit serial input, most significant bit first. In both loading modes the almost-empty offset comes first. When the parity option is latched, data bit 8 is not part of a parallel offset. The bits above it then move down one place to fill the gap.

While loading is still in progress, both outputs read 8. Once both offsets are valid, a done output rises. The offsets then stay frozen until the next master reset, and a partial reset does not change them.

Top module: `ofs_prog_unit`

## Requirements
- R1: When master reset samples select code 000, 001, 010, 011 or 100, both offsets equal 8, 16, 64, 256 or 1024 respectively, and done is high from the first cycle after reset. Code 111 behaves like 000.
- R2: Select code 101 chooses serial loading and code 110 chooses parallel loading. After such a reset, done is low and both offset outputs read 8.
- R3: In parallel mode, the first write with the load strobe high sets the almost-empty offset and the second sets the almost-full offset. Done rises in the cycle after the second write. Until then, both outputs keep reading 8.
- R4: With the parity option off, a parallel write takes the offset from data bits [11:0], and higher bits have no effect.
- R5: With the parity option on, data bit 8 is dropped. The offset is formed from data bits [7:0] as offset bits [7:0] and data bits [12:9] as offset bits [11:8].
- R6: In serial mode, each clock with serial enable high shifts in one bit, most significant first. The first 12 bits form the almost-empty offset and the next 12 form the almost-full offset. Done rises after the 24th bit, and clocks with serial enable low add nothing.
- R7: After done rises, further strobed writes and serial bits leave both offsets and done unchanged until the next master reset.
- R8: Partial reset changes neither the offsets, nor done, nor a load sequence that is already under way.
- R9: Load strobes have no effect in serial mode, and serial bits have no effect in parallel mode.
- R10: A load strobe in the same cycle as master reset is not taken. A master reset during loading restarts the sequence from the almost-empty offset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Write-side clock |
| rst | input | 1 | Master reset, synchronous, active high; samples select and parity |
| part_rst | input | 1 | Partial reset; leaves this block's state untouched |
| sel_i | input | 3 | Offset/method select, sampled during master reset |
| parity_i | input | 1 | Parity option, sampled during master reset |
| wr_stb_i | input | 1 | Parallel load strobe |
| wr_data_i | input | 36 | Port A data bus |
| ser_en_i | input | 1 | Serial shift enable |
| ser_bit_i | input | 1 | Serial offset data |
| ae_ofs_o | output | 12 | Almost-empty offset in use |
| af_ofs_o | output | 12 | Almost-full offset in use |
| done_o | output | 1 | Both offsets hold valid values |

## Verification
Two pairs of events can land in the same cycle. The bench raises the load strobe together with master reset and expects the reset to win: done stays low, and the next two writes still fill the almost-empty offset first. The bench also holds partial reset high across the gap between the two parallel writes. It then checks that the second write still completes the sequence with the expected values. A final partial-reset pulse after completion must leave both outputs unchanged.

// File: rtl/ofs_prog_pkg.sv
`timescale 1ns/1ps
package ofs_prog_pkg;

    typedef enum logic [1:0] {
        MODE_FIXED    = 2'd0,
        MODE_SERIAL   = 2'd1,
        MODE_PARALLEL = 2'd2
    } prog_mode_e;

    typedef struct packed {
        prog_mode_e mode;
        logic       parity_on;
    } prog_cfg_t;

    // Value both outputs carry while a loading sequence is unfinished.
    localparam int unsigned FALLBACK_OFS = 8;
    // Data bus position skipped when the parity option is latched.
    localparam int unsigned PARITY_POS   = 8;

    function automatic prog_mode_e decode_mode(input logic [2:0] s);
        case (s)
            3'b101:  return MODE_SERIAL;
            3'b110:  return MODE_PARALLEL;
            default: return MODE_FIXED;
        endcase
    endfunction

    function automatic int unsigned fixed_offset(input logic [2:0] s);
        case (s)
            3'b000:  return 8;
            3'b001:  return 16;
            3'b010:  return 64;
            3'b011:  return 256;
            3'b100:  return 1024;
            default: return FALLBACK_OFS;
        endcase
    endfunction

endpackage

// File: rtl/ofs_cfg_latch.sv
`timescale 1ns/1ps
module ofs_cfg_latch
    import ofs_prog_pkg::*;
#(
    parameter int unsigned OFS_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       sel_i,
    input  logic             parity_i,
    output prog_cfg_t        cfg_o,
    output logic [OFS_W-1:0] fixed_o
);

    // Configuration is captured only while master reset is asserted.
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_o.mode      <= decode_mode(sel_i);
            cfg_o.parity_on <= parity_i;
            fixed_o         <= OFS_W'(fixed_offset(sel_i));
        end
    end

endmodule

// File: rtl/ofs_par_loader.sv
`timescale 1ns/1ps
module ofs_par_loader
    import ofs_prog_pkg::*;
#(
    parameter int unsigned OFS_W  = 12,
    parameter int unsigned DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_i,
    input  logic              parity_on_i,
    input  logic              stb_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [OFS_W-1:0]  ae_o,
    output logic [OFS_W-1:0]  af_o,
    output logic              done_o
);

    logic [OFS_W-1:0] word_w;
    logic             second_q;
    logic             take_w;

    // Close the gap left by the parity position when the option is on.
    generate
        for (genvar i = 0; i < OFS_W; i++) begin : g_pack
            if (i < PARITY_POS) begin : g_low
                assign word_w[i] = data_i[i];
            end else begin : g_high
                assign word_w[i] = parity_on_i ? data_i[i+1] : data_i[i];
            end
        end
        if (DATA_W > OFS_W + 1) begin : g_spare
            logic unused_hi_bits;
            assign unused_hi_bits = ^data_i[DATA_W-1:OFS_W+1];
        end
    endgenerate

    assign take_w = en_i && stb_i && !done_o;

    always_ff @(posedge clk) begin
        if (rst) begin
            ae_o     <= '0;
            af_o     <= '0;
            second_q <= 1'b0;
            done_o   <= 1'b0;
        end else if (take_w) begin
            if (!second_q) begin
                ae_o     <= word_w;
                second_q <= 1'b1;
            end else begin
                af_o   <= word_w;
                done_o <= 1'b1;
            end
        end
    end

    AST_PAR_FROZEN: assert property (@(posedge clk) disable iff (rst)
        done_o |=> done_o && $stable(ae_o) && $stable(af_o)); // R7

    AST_PAR_DONE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
        $rose(done_o) |-> $past(stb_i) && $past(en_i) && $past(second_q)); // R3

endmodule

// File: rtl/ofs_ser_loader.sv
`timescale 1ns/1ps
module ofs_ser_loader #(
    parameter int unsigned OFS_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic             shift_i,
    input  logic             bit_i,
    output logic [OFS_W-1:0] ae_o,
    output logic [OFS_W-1:0] af_o,
    output logic             done_o
);

    localparam int unsigned TOTAL = 2 * OFS_W;
    localparam int unsigned CNT_W = $clog2(TOTAL + 1);

    logic [TOTAL-1:0] shreg_q;
    logic [CNT_W-1:0] cnt_q;
    logic             take_w;

    assign take_w = en_i && shift_i && !done_o;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg_q <= '0;
            cnt_q   <= '0;
            done_o  <= 1'b0;
        end else if (take_w) begin
            shreg_q <= {shreg_q[TOTAL-2:0], bit_i};
            cnt_q   <= cnt_q + 1'b1;
            if (cnt_q == CNT_W'(TOTAL - 1)) begin
                done_o <= 1'b1;
            end
        end
    end

    // The earlier-shifted half sits in the upper bits.
    assign ae_o = shreg_q[TOTAL-1:OFS_W];
    assign af_o = shreg_q[OFS_W-1:0];

    AST_SER_FROZEN: assert property (@(posedge clk) disable iff (rst)
        done_o |=> done_o && $stable(shreg_q)); // R7

    AST_SER_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(en_i && shift_i) |=> $stable(shreg_q) && $stable(cnt_q)); // R9

    AST_SER_COUNT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        $rose(done_o) |-> cnt_q == CNT_W'(TOTAL)); // R6

endmodule

// File: rtl/ofs_prog_unit.sv
`timescale 1ns/1ps
module ofs_prog_unit
    import ofs_prog_pkg::*;
#(
    parameter int unsigned OFS_W  = 12,
    parameter int unsigned DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              part_rst,
    input  logic [2:0]        sel_i,
    input  logic              parity_i,
    input  logic              wr_stb_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              ser_en_i,
    input  logic              ser_bit_i,
    output logic [OFS_W-1:0]  ae_ofs_o,
    output logic [OFS_W-1:0]  af_ofs_o,
    output logic              done_o
);

    localparam logic [OFS_W-1:0] FALLBACK = OFS_W'(FALLBACK_OFS);

    prog_cfg_t        cfg;
    logic [OFS_W-1:0] fixed_ofs;
    logic [OFS_W-1:0] par_ae, par_af, ser_ae, ser_af;
    logic             par_done, ser_done;

    ofs_cfg_latch #(.OFS_W(OFS_W)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .sel_i    (sel_i),
        .parity_i (parity_i),
        .cfg_o    (cfg),
        .fixed_o  (fixed_ofs)
    );

    ofs_par_loader #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u_par (
        .clk         (clk),
        .rst         (rst),
        .en_i        (cfg.mode == MODE_PARALLEL),
        .parity_on_i (cfg.parity_on),
        .stb_i       (wr_stb_i),
        .data_i      (wr_data_i),
        .ae_o        (par_ae),
        .af_o        (par_af),
        .done_o      (par_done)
    );

    ofs_ser_loader #(.OFS_W(OFS_W)) u_ser (
        .clk     (clk),
        .rst     (rst),
        .en_i    (cfg.mode == MODE_SERIAL),
        .shift_i (ser_en_i),
        .bit_i   (ser_bit_i),
        .ae_o    (ser_ae),
        .af_o    (ser_af),
        .done_o  (ser_done)
    );

    always_comb begin
        ae_ofs_o = FALLBACK;
        af_ofs_o = FALLBACK;
        done_o   = 1'b0;
        case (cfg.mode)
            MODE_FIXED: begin
                ae_ofs_o = fixed_ofs;
                af_ofs_o = fixed_ofs;
                done_o   = 1'b1;
            end
            MODE_SERIAL: begin
                done_o = ser_done;
                if (ser_done) begin
                    ae_ofs_o = ser_ae;
                    af_ofs_o = ser_af;
                end
            end
            MODE_PARALLEL: begin
                done_o = par_done;
                if (par_done) begin
                    ae_ofs_o = par_ae;
                    af_ofs_o = par_af;
                end
            end
            default: ;
        endcase
    end

    AST_PART_RST_HOLD: assert property (@(posedge clk) disable iff (rst)
        part_rst && !wr_stb_i && !ser_en_i |=>
            $stable(ae_ofs_o) && $stable(af_ofs_o) && $stable(done_o)); // R8

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        done_o |=> done_o); // R7

endmodule

// File: tb/ofs_prog_unit_tb_top.sv
`timescale 1ns/1ps
module ofs_prog_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b0;
    logic        part_rst = 1'b0;
    logic [2:0]  sel = 3'b000;
    logic        parity = 1'b0;
    logic        wr_stb = 1'b0;
    logic [35:0] wr_data = '0;
    logic        ser_en = 1'b0;
    logic        ser_bit = 1'b0;
    logic [11:0] ae_ofs, af_ofs;
    logic        done;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    ofs_prog_unit dut_i (
        .clk       (clk),
        .rst       (rst),
        .part_rst  (part_rst),
        .sel_i     (sel),
        .parity_i  (parity),
        .wr_stb_i  (wr_stb),
        .wr_data_i (wr_data),
        .ser_en_i  (ser_en),
        .ser_bit_i (ser_bit),
        .ae_ofs_o  (ae_ofs),
        .af_ofs_o  (af_ofs),
        .done_o    (done)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic chk_state(input string tag, input logic d, input logic [11:0] ae, input logic [11:0] af);
        chk({tag, " done"}, {31'd0, done}, {31'd0, d});
        chk({tag, " ae"}, {20'd0, ae_ofs}, {20'd0, ae});
        chk({tag, " af"}, {20'd0, af_ofs}, {20'd0, af});
    endtask

    task automatic do_reset(input logic [2:0] s, input logic p, input logic stb_too);
        @(negedge clk);
        rst = 1'b1; sel = s; parity = p;
        wr_stb = stb_too; wr_data = 36'h123;
        @(negedge clk);
        rst = 1'b0; wr_stb = 1'b0;
    endtask

    task automatic par_write(input logic [35:0] d);
        wr_stb = 1'b1; wr_data = d;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic ser_shift(input logic [23:0] v, input int hi, input int lo);
        for (int i = hi; i >= lo; i--) begin
            ser_en = 1'b1; ser_bit = v[i];
            @(negedge clk);
        end
        ser_en = 1'b0;
    endtask

    task automatic t_fixed();
        logic [2:0]  codes [6] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd7};
        logic [11:0] vals  [6] = '{12'd8, 12'd16, 12'd64, 12'd256, 12'd1024, 12'd8};
        for (int k = 0; k < 6; k++) begin
            do_reset(codes[k], 1'b0, 1'b0);
            chk_state("R1 fixed", 1'b1, vals[k], vals[k]);
        end
    endtask

    task automatic t_select();
        do_reset(3'b101, 1'b0, 1'b0);
        chk_state("R2 serial select", 1'b0, 12'd8, 12'd8);
        do_reset(3'b110, 1'b0, 1'b0);
        chk_state("R2 parallel select", 1'b0, 12'd8, 12'd8);
    endtask

    task automatic t_parallel();
        do_reset(3'b110, 1'b0, 1'b0);
        par_write(36'h0_0000_173C);
        chk_state("R3 after first write", 1'b0, 12'd8, 12'd8);
        par_write(36'hF_FFF0_0055);
        chk_state("R4 no parity", 1'b1, 12'h73C, 12'h055);
        par_write(36'h0_0000_0FFF);
        chk_state("R7 parallel locked", 1'b1, 12'h73C, 12'h055);
    endtask

    task automatic t_parity();
        do_reset(3'b110, 1'b1, 1'b0);
        par_write(36'h0_0000_173C);
        par_write(36'h0_0000_0100);
        chk_state("R5 parity drop", 1'b1, 12'hB3C, 12'h000);
    endtask

    task automatic t_serial();
        do_reset(3'b101, 1'b0, 1'b0);
        ser_shift(24'hA5C3F1, 23, 12);
        chk_state("R6 half shifted", 1'b0, 12'd8, 12'd8);
        ser_en = 1'b0; ser_bit = 1'b1;
        @(negedge clk);
        ser_shift(24'hA5C3F1, 11, 1);
        chk("R6 done before last bit", {31'd0, done}, 32'd0);
        ser_shift(24'hA5C3F1, 0, 0);
        chk_state("R6 serial", 1'b1, 12'hA5C, 12'h3F1);
        ser_shift(24'hFFFFFF, 23, 0);
        chk_state("R7 serial locked", 1'b1, 12'hA5C, 12'h3F1);
    endtask

    task automatic t_part_rst();
        do_reset(3'b110, 1'b0, 1'b0);
        par_write(36'h111);
        part_rst = 1'b1;
        repeat (2) @(negedge clk);
        part_rst = 1'b0;
        par_write(36'h222);
        chk_state("R8 mid-sequence", 1'b1, 12'h111, 12'h222);
        part_rst = 1'b1;
        repeat (3) @(negedge clk);
        part_rst = 1'b0;
        chk_state("R8 after done", 1'b1, 12'h111, 12'h222);
    endtask

    task automatic t_cross();
        do_reset(3'b101, 1'b0, 1'b0);
        par_write(36'h333);
        par_write(36'h444);
        chk_state("R9 strobe in serial", 1'b0, 12'd8, 12'd8);
        ser_shift(24'h123456, 23, 0);
        chk_state("R9 serial only", 1'b1, 12'h123, 12'h456);
        do_reset(3'b110, 1'b0, 1'b0);
        ser_shift(24'hFFFFFF, 23, 0);
        chk_state("R9 serial in parallel", 1'b0, 12'd8, 12'd8);
        par_write(36'h0AB);
        par_write(36'h0CD);
        chk_state("R9 parallel only", 1'b1, 12'h0AB, 12'h0CD);
    endtask

    task automatic t_collision();
        do_reset(3'b110, 1'b0, 1'b1);
        chk_state("R10 strobe with reset", 1'b0, 12'd8, 12'd8);
        par_write(36'h555);
        chk("R10 one write not done", {31'd0, done}, 32'd0);
        do_reset(3'b110, 1'b0, 1'b0);
        par_write(36'h666);
        chk("R10 restart first", {31'd0, done}, 32'd0);
        par_write(36'h777);
        chk_state("R10 restart", 1'b1, 12'h666, 12'h777);
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_fixed();
        t_select();
        t_parallel();
        t_parity();
        t_serial();
        t_part_rst();
        t_cross();
        t_collision();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule